// File: doc/BRIEF.md
# Relocatable Memory Map Decoder

This block turns a 16-bit CPU address into a one-hot select that names the on-chip resource answering that address: a debug ROM, the register block, RAM, EEPROM, flash, or external memory when nothing internal claims the address. The register block, RAM and EEPROM can be moved. Their base addresses sit in small mapping registers that software writes at start-up. A fixed precedence settles any overlap between windows.

The mapping registers are guarded according to the operating mode. In normal modes each register takes only its first write. In special modes the base registers take any number of writes. The port-emulation bit follows an inverted rule in special modes: its first write is dropped, and later writes are accepted. A write does not change the decode in the following cycle. It takes effect one cycle after that. When the port-emulation bit is set in expanded mode, a four-byte hole opens in the register block. Accesses in that hole pass to the next resource in precedence order.

Top module: `memmap_decoder`

## Requirements
- R1: After reset the register block base is 0x0000, the RAM base is 0x0800, the EEPROM base is 0x1000 and the port-emulation bit is 0.
- R2: The register window is 512 bytes long. It starts at the 5-bit register-base field shifted to address bits 15:11, so it can sit on any 2 KB boundary.
- R3: Exactly one select is high for every address. `sel` bit 0 is debug ROM, bit 1 is registers, bit 2 is RAM, bit 3 is EEPROM, bit 4 is flash and bit 5 is external. Precedence runs from bit 0 (highest) to bit 4, and external takes every address no other resource claims.
- R4: The debug ROM window is 0xFF00 to 0xFFFF. It is selected only while `dbg_active` is high.
- R5: In normal mode (`mode_special`=0) each mapping register keeps the value of its first write. All later writes to it are ignored.
- R6: In special mode the register, RAM and EEPROM base registers accept every write.
- R7: In special mode the first write to the port-emulation register is ignored and every later write is accepted. In normal mode only its first write is accepted.
- R8: `rd_data` shows a written value from the cycle after the write. The decode still uses the old mapping in that cycle and switches to the new mapping one cycle later.
- R9: The register-block offsets 0x08 to 0x0B leave the register window only when the port-emulation bit is 1 and `mode_expanded` is 1. The addresses in that hole go to the next resource in precedence.
- R10: Register select `wr_sel`/`rd_sel` values map as follows: 0 is the register base (data bits 7:3), 1 is the RAM base (data bits 7:3), 2 is the EEPROM base (data bits 7:4) and 3 is port emulation (data bit 0). All other bits read as 0.
- R11: The RAM window is 1 KB at the RAM field shifted to bits 15:11. The EEPROM window is 768 bytes at the EEPROM field shifted to bits 15:12. Flash covers 0x8000 to 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_special | input | 1 | 1 selects special mode, 0 selects normal mode |
| mode_expanded | input | 1 | 1 selects expanded mode, 0 selects single-chip mode |
| dbg_active | input | 1 | Enables the debug ROM window |
| wr_en | input | 1 | Write strobe for the mapping registers |
| wr_sel | input | 2 | Mapping register to write |
| wr_data | input | 8 | Write data |
| rd_sel | input | 2 | Mapping register to read |
| rd_data | output | 8 | Read data |
| addr | input | 16 | CPU address to decode |
| sel | output | 6 | One-hot resource select |

## Verification
The bench moves the register block on top of the EEPROM and then the RAM. A wrong precedence would select a lower-priority memory at an address the registers should own. It probes the same address in the write cycle and in the two cycles after it. A design that updates the decode too early or too late would switch selects one cycle off. It sends repeated writes in both modes, including the dropped first write to the port-emulation bit. A wrong protection rule would show up as a readback or port-hole decode that differs from the model. It also opens the port hole in both single-chip and expanded modes, so a design that ignored the mode would remove registers it must keep.

// File: rtl/memmap_pkg.sv
package memmap_pkg;

    localparam int ADDR_W       = 16;
    localparam int DATA_W       = 8;
    localparam int NUM_RES      = 6;
    localparam int NUM_MAP_REGS = 4;

    // Base field widths; each field supplies the top bits of its base address
    localparam int REG_FIELD_W = 5;
    localparam int RAM_FIELD_W = 5;
    localparam int EE_FIELD_W  = 4;

    typedef enum logic [2:0] {
        RES_DBG   = 3'd0,
        RES_REG   = 3'd1,
        RES_RAM   = 3'd2,
        RES_EE    = 3'd3,
        RES_FLASH = 3'd4,
        RES_EXT   = 3'd5
    } res_e;

    typedef enum logic [1:0] {
        MR_REG  = 2'd0,
        MR_RAM  = 2'd1,
        MR_EE   = 2'd2,
        MR_MISC = 2'd3
    } map_reg_e;

    typedef struct packed {
        logic [REG_FIELD_W-1:0] reg_base;
        logic [RAM_FIELD_W-1:0] ram_base;
        logic [EE_FIELD_W-1:0]  ee_base;
        logic                   port_emu;
    } map_cfg_t;

    // Address a falls in [base, base+size)
    function automatic logic in_window(logic [ADDR_W-1:0] a,
                                       logic [ADDR_W-1:0] base,
                                       logic [ADDR_W:0]   size);
        logic [ADDR_W:0] diff;
        diff = {1'b0, a} - {1'b0, base};
        return (a >= base) && (diff < size);
    endfunction

endpackage

// File: rtl/memmap_cfg_regs.sv
module memmap_cfg_regs
    import memmap_pkg::*;
#(
    parameter logic [REG_FIELD_W-1:0] REG_BASE_RST = 5'h00,
    parameter logic [RAM_FIELD_W-1:0] RAM_BASE_RST = 5'h01,
    parameter logic [EE_FIELD_W-1:0]  EE_BASE_RST  = 4'h1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    mode_special,
    input  logic                    wr_en,
    input  logic [1:0]              wr_sel,
    input  logic [DATA_W-1:0]       wr_data,
    output map_cfg_t                cfg_shadow,
    output map_cfg_t                cfg_active,
    output logic [NUM_MAP_REGS-1:0] written
);

    localparam map_cfg_t CFG_RST = '{
        reg_base: REG_BASE_RST,
        ram_base: RAM_BASE_RST,
        ee_base:  EE_BASE_RST,
        port_emu: 1'b0
    };

    logic [NUM_MAP_REGS-1:0] wr_hit;
    logic [NUM_MAP_REGS-1:0] accept;

    for (genvar g = 0; g < NUM_MAP_REGS; g++) begin : g_guard
        assign wr_hit[g] = wr_en && (wr_sel == 2'(g));
        if (g == int'(MR_MISC)) begin : g_emu
            // special: all but the first write; normal: only the first
            assign accept[g] = wr_hit[g] &&
                               (mode_special ? written[g] : !written[g]);
        end else begin : g_base
            assign accept[g] = wr_hit[g] && (mode_special || !written[g]);
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                written[g] <= 1'b0;
            end else if (wr_hit[g]) begin
                written[g] <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_shadow <= CFG_RST;
        end else begin
            if (accept[MR_REG])
                cfg_shadow.reg_base <= wr_data[DATA_W-1 -: REG_FIELD_W];
            if (accept[MR_RAM])
                cfg_shadow.ram_base <= wr_data[DATA_W-1 -: RAM_FIELD_W];
            if (accept[MR_EE])
                cfg_shadow.ee_base  <= wr_data[DATA_W-1 -: EE_FIELD_W];
            if (accept[MR_MISC])
                cfg_shadow.port_emu <= wr_data[0];
        end
    end

    // Second stage: the decode sees a new mapping one cycle after readback
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_active <= CFG_RST;
        end else begin
            cfg_active <= cfg_shadow;
        end
    end

endmodule

// File: rtl/memmap_readback.sv
module memmap_readback
    import memmap_pkg::*;
(
    input  logic [1:0]        rd_sel,
    input  map_cfg_t          cfg,
    output logic [DATA_W-1:0] rd_data
);

    always_comb begin
        rd_data = '0;
        unique case (map_reg_e'(rd_sel))
            MR_REG:  rd_data[DATA_W-1 -: REG_FIELD_W] = cfg.reg_base;
            MR_RAM:  rd_data[DATA_W-1 -: RAM_FIELD_W] = cfg.ram_base;
            MR_EE:   rd_data[DATA_W-1 -: EE_FIELD_W]  = cfg.ee_base;
            MR_MISC: rd_data[0]                       = cfg.port_emu;
            default: rd_data = '0;
        endcase
    end

endmodule

// File: rtl/memmap_prio_decode.sv
module memmap_prio_decode
    import memmap_pkg::*;
#(
    parameter int                REG_BYTES  = 512,
    parameter int                RAM_BYTES  = 1024,
    parameter int                EE_BYTES   = 768,
    parameter int                PORT_OFS   = 8,
    parameter int                PORT_BYTES = 4,
    parameter logic [ADDR_W-1:0] DBG_LO     = 16'hFF00,
    parameter logic [ADDR_W-1:0] FLASH_LO   = 16'h8000
) (
    input  logic [ADDR_W-1:0]  addr,
    input  map_cfg_t           cfg,
    input  logic               dbg_active,
    input  logic               mode_expanded,
    output logic [NUM_RES-1:0] sel
);

    localparam int REG_SHIFT = ADDR_W - REG_FIELD_W;
    localparam int RAM_SHIFT = ADDR_W - RAM_FIELD_W;
    localparam int EE_SHIFT  = ADDR_W - EE_FIELD_W;

    logic [ADDR_W-1:0]  reg_lo, ram_lo, ee_lo, port_lo;
    logic               port_hole;
    logic [NUM_RES-1:0] hit;

    assign reg_lo  = {cfg.reg_base, {REG_SHIFT{1'b0}}};
    assign ram_lo  = {cfg.ram_base, {RAM_SHIFT{1'b0}}};
    assign ee_lo   = {cfg.ee_base,  {EE_SHIFT{1'b0}}};
    assign port_lo = reg_lo + ADDR_W'(PORT_OFS);

    assign port_hole = cfg.port_emu && mode_expanded &&
                       in_window(addr, port_lo, (ADDR_W+1)'(PORT_BYTES));

    assign hit[RES_DBG]   = dbg_active && (addr >= DBG_LO);
    assign hit[RES_REG]   = in_window(addr, reg_lo, (ADDR_W+1)'(REG_BYTES)) && !port_hole;
    assign hit[RES_RAM]   = in_window(addr, ram_lo, (ADDR_W+1)'(RAM_BYTES));
    assign hit[RES_EE]    = in_window(addr, ee_lo,  (ADDR_W+1)'(EE_BYTES));
    assign hit[RES_FLASH] = addr >= FLASH_LO;
    assign hit[RES_EXT]   = 1'b1;

    // Lowest index wins
    always_comb begin
        logic taken;
        sel   = '0;
        taken = 1'b0;
        for (int i = 0; i < NUM_RES; i++) begin
            if (hit[i] && !taken) begin
                sel[i] = 1'b1;
                taken  = 1'b1;
            end
        end
    end

endmodule

// File: rtl/memmap_decoder.sv
module memmap_decoder
    import memmap_pkg::*;
#(
    parameter logic [4:0]  REG_BASE_RST = 5'h00,
    parameter logic [4:0]  RAM_BASE_RST = 5'h01,
    parameter logic [3:0]  EE_BASE_RST  = 4'h1,
    parameter int          REG_BYTES    = 512,
    parameter int          RAM_BYTES    = 1024,
    parameter int          EE_BYTES     = 768,
    parameter int          PORT_OFS     = 8,
    parameter int          PORT_BYTES   = 4,
    parameter logic [15:0] DBG_LO       = 16'hFF00,
    parameter logic [15:0] FLASH_LO     = 16'h8000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        mode_special,
    input  logic        mode_expanded,
    input  logic        dbg_active,
    input  logic        wr_en,
    input  logic [1:0]  wr_sel,
    input  logic [7:0]  wr_data,
    input  logic [1:0]  rd_sel,
    output logic [7:0]  rd_data,
    input  logic [15:0] addr,
    output logic [5:0]  sel
);

    map_cfg_t                cfg_shadow;
    map_cfg_t                cfg_active;
    logic [NUM_MAP_REGS-1:0] written;

    memmap_cfg_regs #(
        .REG_BASE_RST (REG_BASE_RST),
        .RAM_BASE_RST (RAM_BASE_RST),
        .EE_BASE_RST  (EE_BASE_RST)
    ) u_regs (
        .clk          (clk),
        .rst          (rst),
        .mode_special (mode_special),
        .wr_en        (wr_en),
        .wr_sel       (wr_sel),
        .wr_data      (wr_data),
        .cfg_shadow   (cfg_shadow),
        .cfg_active   (cfg_active),
        .written      (written)
    );

    memmap_readback u_rb (
        .rd_sel  (rd_sel),
        .cfg     (cfg_shadow),
        .rd_data (rd_data)
    );

    memmap_prio_decode #(
        .REG_BYTES  (REG_BYTES),
        .RAM_BYTES  (RAM_BYTES),
        .EE_BYTES   (EE_BYTES),
        .PORT_OFS   (PORT_OFS),
        .PORT_BYTES (PORT_BYTES),
        .DBG_LO     (DBG_LO),
        .FLASH_LO   (FLASH_LO)
    ) u_dec (
        .addr          (addr),
        .cfg           (cfg_active),
        .dbg_active    (dbg_active),
        .mode_expanded (mode_expanded),
        .sel           (sel)
    );

endmodule

// File: rtl/memmap_decoder_chk.sv
module memmap_decoder_chk
    import memmap_pkg::*;
(
    input logic                    clk,
    input logic                    rst,
    input logic                    mode_special,
    input logic                    mode_expanded,
    input logic                    dbg_active,
    input logic                    wr_en,
    input logic [1:0]              wr_sel,
    input logic [15:0]             addr,
    input logic [5:0]              sel,
    input map_cfg_t                cfg_shadow,
    input map_cfg_t                cfg_active,
    input logic [NUM_MAP_REGS-1:0] written
);

    logic [15:0] port_lo;
    logic        in_port;
    assign port_lo = {cfg_active.reg_base, 11'b0} + 16'd8;
    assign in_port = (addr >= port_lo) && (addr < port_lo + 16'd4);

    a_r3_one_select: assert property (@(posedge clk) disable iff (rst)
        $countones(sel) == 1);

    a_r4_debug_wins: assert property (@(posedge clk) disable iff (rst)
        (dbg_active && addr >= 16'hFF00) |-> sel == 6'b000001);

    a_r4_debug_gated: assert property (@(posedge clk) disable iff (rst)
        !dbg_active |-> !sel[0]);

    a_r5_normal_locked: assert property (@(posedge clk) disable iff (rst)
        (!mode_special && written[MR_REG]) |=> $stable(cfg_shadow.reg_base));

    a_r7_first_emu_dropped: assert property (@(posedge clk) disable iff (rst)
        (mode_special && !written[MR_MISC] && wr_en && wr_sel == 2'd3)
        |=> $stable(cfg_shadow.port_emu));

    a_r8_second_stage: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> cfg_active == $past(cfg_shadow));

    a_r9_single_chip_port: assert property (@(posedge clk) disable iff (rst)
        (!mode_expanded && in_port && !(dbg_active && addr >= 16'hFF00))
        |-> sel == 6'b000010);

endmodule

bind memmap_decoder memmap_decoder_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .mode_special  (mode_special),
    .mode_expanded (mode_expanded),
    .dbg_active    (dbg_active),
    .wr_en         (wr_en),
    .wr_sel        (wr_sel),
    .addr          (addr),
    .sel           (sel),
    .cfg_shadow    (cfg_shadow),
    .cfg_active    (cfg_active),
    .written       (written)
);

// File: tb/memmap_decoder_test.sv
module memmap_decoder_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode_special = 1'b0;
    logic        mode_expanded = 1'b0;
    logic        dbg_active = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [7:0]  wr_data = '0;
    logic [1:0]  rd_sel = '0;
    logic [7:0]  rd_data;
    logic [15:0] addr = '0;
    logic [5:0]  sel;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    // behavioural model state: shadow (m_*), active (a_*), written flags
    int m_reg, m_ram, m_ee, m_emu;
    int a_reg, a_ram, a_ee, a_emu;
    bit wflag [4];

    always #2.5 clk = ~clk;

    memmap_decoder uut (
        .clk(clk), .rst(rst), .mode_special(mode_special),
        .mode_expanded(mode_expanded), .dbg_active(dbg_active),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .addr(addr), .sel(sel)
    );

    function automatic logic [5:0] ref_sel(int a);
        int rb = a_reg * 2048;
        int mb = a_ram * 2048;
        int eb = a_ee * 4096;
        bit hole = (a_emu != 0) && mode_expanded && a >= rb + 8 && a < rb + 12;
        if (dbg_active && a >= 65280) return 6'b000001;
        if (a >= rb && a < rb + 512 && !hole) return 6'b000010;
        if (a >= mb && a < mb + 1024) return 6'b000100;
        if (a >= eb && a < eb + 768) return 6'b001000;
        if (a >= 32768) return 6'b010000;
        return 6'b100000;
    endfunction

    function automatic logic [7:0] ref_rd(int s);
        case (s)
            0: return 8'(m_reg * 8);
            1: return 8'(m_ram * 8);
            2: return 8'(m_ee * 16);
            default: return 8'(m_emu);
        endcase
    endfunction

    task automatic model_reset();
        m_reg = 0; m_ram = 1; m_ee = 1; m_emu = 0;
        a_reg = 0; a_ram = 1; a_ee = 1; a_emu = 0;
        foreach (wflag[i]) wflag[i] = 0;
    endtask

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp, string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h (addr %h)", tag, what, act, exp, addr);
        end
    endtask

    task automatic step(bit r, bit we, int ws, int wd, int a, bit dbg, int rs, string tag);
        bit acc;
        @(negedge clk);
        rst = r; wr_en = we; wr_sel = 2'(ws); wr_data = 8'(wd);
        addr = 16'(a); dbg_active = dbg; rd_sel = 2'(rs);
        #1;
        check(tag, {2'b00, sel}, {2'b00, ref_sel(a)}, "sel");
        check("R10", rd_data, ref_rd(rs), "rd_data");
        @(posedge clk);
        if (r) begin
            model_reset();
        end else begin
            a_reg = m_reg; a_ram = m_ram; a_ee = m_ee; a_emu = m_emu;
            if (we) begin
                if (ws == 3) acc = mode_special ? wflag[3] : !wflag[3];
                else         acc = mode_special || !wflag[ws];
                wflag[ws] = 1;
                if (acc) begin
                    case (ws)
                        0: m_reg = (wd >> 3) & 31;
                        1: m_ram = (wd >> 3) & 31;
                        2: m_ee  = (wd >> 4) & 15;
                        default: m_emu = wd & 1;
                    endcase
                end
            end
        end
    endtask

    task automatic probe(int a, bit dbg, string tag);
        step(0, 0, 0, 0, a, dbg, 0, tag);
    endtask

    task automatic do_reset(bit sp, bit ex);
        @(negedge clk);
        mode_special = sp; mode_expanded = ex;
        step(1, 0, 0, 0, 0, 0, 0, "R1");
        step(0, 0, 0, 0, 0, 0, 0, "R1");
    endtask

    task automatic random_run(int n);
        for (int i = 0; i < n; i++) begin
            int a, pick;
            pick = $urandom_range(0, 5);
            case (pick)
                0: a = a_reg * 2048 + $urandom_range(0, 15);
                1: a = a_reg * 2048 + $urandom_range(500, 520);
                2: a = a_ram * 2048 + $urandom_range(1015, 1030);
                3: a = a_ee * 4096 + $urandom_range(760, 775);
                default: a = $urandom_range(0, 65535);
            endcase
            if (a > 65535) a = 65535;
            step(0, $urandom_range(0, 7) == 0, $urandom_range(0, 3),
                 $urandom_range(0, 255), a, $urandom_range(0, 3) == 0,
                 $urandom_range(0, 3), "R3");
        end
    endtask

    initial begin
        #1ms;
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        model_reset();
        // Normal, single-chip
        do_reset(0, 0);
        for (int k = 0; k < 4; k++) step(0, 0, 0, 0, 0, 0, k, "R1");
        probe(16'h0000, 0, "R2"); probe(16'h01FF, 0, "R2"); probe(16'h0200, 0, "R2");
        probe(16'h0800, 0, "R11"); probe(16'h0BFF, 0, "R11"); probe(16'h0C00, 0, "R11");
        probe(16'h1000, 0, "R11"); probe(16'h12FF, 0, "R11"); probe(16'h1300, 0, "R11");
        probe(16'h7FFF, 0, "R11"); probe(16'h8000, 0, "R11");
        probe(16'hFF00, 0, "R4"); probe(16'hFF00, 1, "R4"); probe(16'hFEFF, 1, "R4");
        // move registers onto EEPROM: write cycle, then old decode, then new
        step(0, 1, 0, 8'h10, 16'h1000, 0, 0, "R8");
        probe(16'h1000, 0, "R8");
        probe(16'h1000, 0, "R8");
        probe(16'h11FF, 0, "R3"); probe(16'h1200, 0, "R3");
        step(0, 1, 0, 8'h28, 16'h1000, 0, 0, "R5");
        probe(16'h1000, 0, "R5"); probe(16'h2800, 0, "R5");
        step(0, 1, 3, 1, 0, 0, 3, "R7");
        step(0, 1, 3, 0, 0, 0, 3, "R7");
        probe(16'h1008, 0, "R9"); probe(16'h100B, 0, "R9");
        random_run(1500);

        // Special, expanded
        do_reset(1, 1);
        step(0, 1, 3, 1, 0, 0, 3, "R7");
        step(0, 0, 0, 0, 16'h0008, 0, 3, "R7");
        probe(16'h0008, 0, "R9");
        step(0, 1, 3, 1, 0, 0, 3, "R7");
        step(0, 0, 0, 0, 16'h0008, 0, 3, "R7");
        probe(16'h0008, 0, "R9"); probe(16'h0007, 0, "R9");
        probe(16'h000C, 0, "R9"); probe(16'h000B, 0, "R9");
        step(0, 1, 1, 8'h00, 16'h0008, 0, 1, "R6");
        probe(16'h0008, 0, "R6"); probe(16'h0008, 0, "R9");
        probe(16'h000C, 0, "R3");
        step(0, 1, 0, 8'hF8, 16'hF800, 0, 0, "R6");
        step(0, 1, 0, 8'h40, 16'h4000, 0, 0, "R6");
        probe(16'h4000, 0, "R6"); probe(16'h4008, 0, "R9");
        probe(16'hF800, 0, "R6");
        random_run(3000);

        // Normal, expanded
        do_reset(0, 1);
        step(0, 1, 3, 1, 0, 0, 3, "R7");
        probe(16'h0009, 0, "R9");
        probe(16'h0009, 0, "R9");
        random_run(3000);

        // Special, single-chip
        do_reset(1, 0);
        random_run(2000);

        finished = 1;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule